// File: doc/BRIEF.md
# Extend and Logic Execute Unit

This block is one execute slice of a 32-bit load/store processor. Each time `issue` is high it decodes one instruction word. The word is a first halfword, plus a second halfword that only the immediate form uses. The unit then performs one of these operations:

- in-place byte or halfword extension, sign or zero;
- register exclusive-OR;
- exclusive-OR with a 16-bit immediate;
- a bitwise AND test that changes only the flags.

The caller reads the two source registers named by the instruction and presents their values. One clock edge later the unit returns a write-back value, a destination index and a write strobe. It also returns new S, Z and OV values with one shared update strobe.

The first halfword uses this layout:

- bits 15:11 hold the second-operand field (`f2`), which is also the destination for the logic forms;
- bits 10:5 hold the operation code;
- bits 4:0 hold the first-operand field (`f1`).

The extend forms need bits 15:8 to be zero and use only `f1`, as both source and destination. Any encoding the unit does not recognise sets `illegal` and blocks every write and flag update. The register file, fetch and all other flags belong to the surrounding core.

Top module: `xlog_exec`

## Requirements
- R1: An extend form is a first halfword with bits 15:8 zero and bit 7 one. Bits 7:5 select the form: 101 sign-extends bits 7:0, 111 sign-extends bits 15:0, 100 zero-extends bits 7:0, and 110 zero-extends bits 15:0 of the `f1` register value `op1`.
- R2: An extend writes its result to register index `f1` with `wb_en` high and `flag_upd` low.
- R3: Register XOR has opcode 001001. It writes `op2 ^ op1` to index `f2`.
- R4: XOR immediate has opcode 110101. It writes `op1 ^ {16'b0, imm}` to index `f2`, where `imm` is the second halfword.
- R5: The AND test has opcode 001011. It places `op2 & op1` on `wb_data`, holds `wb_en` low and raises `flag_upd`.
- R6: For the XOR, XOR-immediate and AND-test forms, `flag_upd` is high. `flag_s` is bit 31 of the result, `flag_z` is high exactly when the 32-bit result is zero, and `flag_ov` is 0.
- R7: Outputs appear on the first rising edge after the edge where `issue` is sampled high. A cycle without `issue` leaves `wb_en`, `flag_upd` and `illegal` low on the following cycle.
- R8: An extend form with `f1` equal to zero, an extend pattern with bits 15:8 nonzero, or any other opcode raises `illegal` and holds `wb_en` and `flag_upd` low.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction present this cycle |
| insn_hi | input | 16 | First instruction halfword |
| insn_lo | input | 16 | Second halfword (immediate) |
| op1 | input | 32 | Value of register `f1` |
| op2 | input | 32 | Value of register `f2` |
| wb_data | output | 32 | Result value |
| wb_idx | output | 5 | Destination register index |
| wb_en | output | 1 | Register write strobe |
| flag_s | output | 1 | New S flag |
| flag_z | output | 1 | New Z flag |
| flag_ov | output | 1 | New OV flag |
| flag_upd | output | 1 | S/Z/OV update strobe |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The assertions check four properties on every cycle:

- an illegal encoding never writes or updates flags;
- OV is always cleared when flags update;
- Z agrees with the result whenever flags update;
- a cycle without `issue` produces no strobe, and an AND test never writes while an extend never touches flags.

The arithmetic values themselves can only be shown by the bench's scenarios. These are the exact extension of each width and sign, zero extension of the immediate, and the register index chosen for each form.

// File: rtl/xlog_exec.sv
module xlog_exec #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [15:0]     insn_hi,
  input  logic [15:0]     insn_lo,
  input  logic [XLEN-1:0] op1,
  input  logic [XLEN-1:0] op2,
  output logic [XLEN-1:0] wb_data,
  output logic [RIDX-1:0] wb_idx,
  output logic            wb_en,
  output logic            flag_s,
  output logic            flag_z,
  output logic            flag_ov,
  output logic            flag_upd,
  output logic            illegal
);
  localparam logic [5:0] OP_XOR  = 6'b001001;
  localparam logic [5:0] OP_TST  = 6'b001011;
  localparam logic [5:0] OP_XORI = 6'b110101;

  logic [RIDX-1:0] f1, f2;
  logic [5:0]      opc;
  logic            is_ext, is_xor, is_xori, is_tst, ok;
  logic [XLEN-1:0] res;
  logic [RIDX-1:0] dst;

  assign f1      = insn_hi[RIDX-1:0];
  assign f2      = insn_hi[15:11];
  assign opc     = insn_hi[10:5];
  assign is_ext  = insn_hi[15:8] == 8'h00 && insn_hi[7] && f1 != '0;
  assign is_xor  = opc == OP_XOR;
  assign is_xori = opc == OP_XORI;
  assign is_tst  = opc == OP_TST;
  assign ok      = is_ext || is_xor || is_xori || is_tst;

  always_comb begin
    res = '0;
    dst = f2;
    if (is_ext) begin
      dst = f1;
      unique case (insn_hi[6:5])
        2'b00: res = {{(XLEN-8){1'b0}}, op1[7:0]};
        2'b01: res = {{(XLEN-8){op1[7]}}, op1[7:0]};
        2'b10: res = {{(XLEN-16){1'b0}}, op1[15:0]};
        default: res = {{(XLEN-16){op1[15]}}, op1[15:0]};
      endcase
    end else if (is_xor) begin
      res = op2 ^ op1;
    end else if (is_xori) begin
      res = op1 ^ {{(XLEN-16){1'b0}}, insn_lo};
    end else if (is_tst) begin
      res = op2 & op1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_data  <= '0;
      wb_idx   <= '0;
      wb_en    <= 1'b0;
      flag_s   <= 1'b0;
      flag_z   <= 1'b0;
      flag_ov  <= 1'b0;
      flag_upd <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      wb_data  <= res;
      wb_idx   <= dst;
      wb_en    <= issue && ok && !is_tst;
      flag_s   <= res[XLEN-1];
      flag_z   <= res == '0;
      flag_ov  <= 1'b0;
      flag_upd <= issue && ok && !is_ext;
      illegal  <= issue && !ok;
    end
  end

  p_illegal_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en && !flag_upd);

  p_ov_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |-> !flag_ov);

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |-> flag_z == (wb_data == '0));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !wb_en && !flag_upd && !illegal);

  p_tst_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_tst |=> !wb_en && flag_upd);

  p_ext_no_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && is_ext |=> wb_en && !flag_upd && wb_idx == $past(f1));
endmodule

// File: tb/sim_xlog_exec.sv
module sim_xlog_exec;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue = 0;
  logic [15:0] insn_hi = 0, insn_lo = 0;
  logic [31:0] op1 = 0, op2 = 0;
  logic [31:0] wb_data;
  logic [4:0]  wb_idx;
  logic        wb_en, flag_s, flag_z, flag_ov, flag_upd, illegal;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlog_exec u0 (.clk, .rst_n, .issue, .insn_hi, .insn_lo, .op1, .op2,
    .wb_data, .wb_idx, .wb_en, .flag_s, .flag_z, .flag_ov, .flag_upd, .illegal);

  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    logic [4:0]  idx;
    logic        we;
    logic        fu;
    logic        s;
    logic        z;
    logic        ill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{16'h00A3, 16'h0, 32'h12345680, 32'h0, 32'hFFFFFF80, 5'd3,  1, 0, 0, 0, 0}, // R1 sxb
    '{16'h00E7, 16'h0, 32'hABCD1234, 32'h0, 32'h00001234, 5'd7,  1, 0, 0, 0, 0}, // R1 sxh +
    '{16'h00E7, 16'h0, 32'h00008001, 32'h0, 32'hFFFF8001, 5'd7,  1, 0, 0, 0, 0}, // R1 sxh -
    '{16'h009F, 16'h0, 32'hFFFFFFF0, 32'h0, 32'h000000F0, 5'd31, 1, 0, 0, 0, 0}, // R1 zxb
    '{16'h00C1, 16'h0, 32'hFFFF8765, 32'h0, 32'h00008765, 5'd1,  1, 0, 0, 0, 0}, // R2 zxh
    '{16'h2922, 16'h0, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 5'd5, 1, 1, 1, 0, 0}, // R3
    '{16'h2124, 16'h0, 32'h00001234, 32'h00001234, 32'h0, 5'd4, 1, 1, 0, 1, 0},       // R3 zero
    '{16'h4EA1, 16'h8000, 32'h80000000, 32'h0, 32'h80008000, 5'd9, 1, 1, 1, 0, 0},    // R4
    '{16'h4EA1, 16'hFFFF, 32'h0000FFFF, 32'h0, 32'h0, 5'd9, 1, 1, 0, 1, 0},           // R4 zero
    '{16'h3168, 16'h0, 32'hFF00FF00, 32'h00FF00FF, 32'h0, 5'd0, 0, 1, 0, 1, 0},       // R5
    '{16'h0962, 16'h0, 32'h80000001, 32'h80000000, 32'h80000000, 5'd0, 0, 1, 1, 0, 0}, // R5 S
    '{16'h00A0, 16'h0, 32'h12345678, 32'h0, 32'h0, 5'd0, 0, 0, 0, 0, 1},             // R8 f1=0
    '{16'h08A3, 16'h0, 32'h12345678, 32'h0, 32'h0, 5'd0, 0, 0, 0, 0, 1},             // R8 hi bits
    '{16'h0000, 16'h0, 32'h12345678, 32'h0, 32'h0, 5'd0, 0, 0, 0, 0, 1}              // R8 unknown
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    issue = 1; insn_hi = 16'h2922; op1 = 32'h1; op2 = 32'h2;
    repeat (3) @(negedge clk);
    chk("R9 reset wb_data", wb_data, 0);
    chk("R9 reset strobes", {27'b0, wb_en, flag_upd, illegal, flag_s, flag_z}, 0);
    rst_n = 1; issue = 0;
    @(negedge clk);
    chk("R7 idle after reset", {29'b0, wb_en, flag_upd, illegal}, 0);

    for (int i = 0; i < NV; i++) begin
      insn_hi = VT[i].hi; insn_lo = VT[i].lo; op1 = VT[i].a; op2 = VT[i].b; issue = 1;
      @(negedge clk);
      chk($sformatf("R1-R8 vec%0d data", i), wb_data, VT[i].ill ? wb_data : VT[i].d);
      chk($sformatf("R2/R3/R4/R5 vec%0d we", i), {31'b0, wb_en}, {31'b0, VT[i].we});
      if (VT[i].we) chk($sformatf("R2/R3/R4 vec%0d idx", i), {27'b0, wb_idx}, {27'b0, VT[i].idx});
      chk($sformatf("R6 vec%0d upd", i), {31'b0, flag_upd}, {31'b0, VT[i].fu});
      if (VT[i].fu)
        chk($sformatf("R6 vec%0d s/z/ov", i), {29'b0, flag_s, flag_z, flag_ov},
            {29'b0, VT[i].s, VT[i].z, 1'b0});
      chk($sformatf("R8 vec%0d illegal", i), {31'b0, illegal}, {31'b0, VT[i].ill});
    end

    // R7: an instruction held on the pins without issue has no effect
    insn_hi = 16'h2922; issue = 0;
    @(negedge clk);
    chk("R7 no issue", {29'b0, wb_en, flag_upd, illegal}, 0);

    // R7: result appears one edge later, not earlier
    issue = 1; insn_hi = 16'h00C1; op1 = 32'hCAFE1234;
    @(posedge clk); #1;
    chk("R7 one edge", wb_data, 32'h00001234);
    issue = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 drop", {31'b0, wb_en}, 0);

    // R9: reset mid-run clears outputs
    issue = 1; insn_hi = 16'h2922; op1 = 32'hF; op2 = 32'h0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R9 mid reset", {wb_data[26:0], wb_en, flag_upd, illegal, flag_s, flag_z}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule